// File: doc/BRIEF.md
# Quad Double-Buffered DAC Register Bank

This block is the digital core of a four-channel, 16-bit converter with a parallel host bus. Each channel has two register levels. The first level is a staging (input) register that the host writes. The second level is the DAC register, which holds the code the analog section converts. The host picks a channel with a 2-bit address. A rising chip select with the direction pin low stores the bus word in that channel's staging register. With the direction pin high and chip select low, the staging register of the addressed channel is driven back onto the bus.

A rising edge on the load strobe moves all four staging values into the DAC registers in one cycle, so every output changes at the same time. A rising edge on the clear strobe zeroes the DAC registers and does not touch the staging registers. A low level on the power-down pin marks every output as high impedance but keeps the DAC codes, so the outputs come back where they were. All strobes are resynchronised into the system clock and acted on at their rising edges.

Top module: `quad_dac_regbank`

## Requirements
- R1: After the active-low power-on reset, all four DAC codes and all four staging registers are zero.
- R2: A low-to-high transition of `csN` while `rdWrN` is 0 stores `dataIn` into the staging register of the channel chosen by `chAddr` (0..3 selects channel A..D). No other staging register changes and no DAC code changes.
- R3: While `csN` is 0 and `rdWrN` is 1, `dataOutEn` is 1 and `dataOut` shows the staging register of the addressed channel. Otherwise `dataOutEn` is 0. A `csN` rise while `rdWrN` is 1 writes nothing.
- R4: A rising edge on `loadIn` copies every staging register into its DAC register. The staging registers keep their contents.
- R5: A rising edge on `clearIn` sets all DAC codes to zero and leaves every staging register unchanged.
- R6: While `pwrDnN` is 0, every bit of `chOutEn` is 0 and the DAC codes are held. A clear that occurs during power-down still zeroes them, so the outputs return at code zero.
- R7: If a write edge and a load edge are detected in the same cycle, the load copies the staging values from before that write.
- R8: If a load edge and a clear edge are detected in the same cycle, the DAC registers end at zero.
- R9: Only rising edges act. Holding `loadIn` high does not pass later writes through to the DAC codes.
- R10: Codes are 16-bit unsigned binary with bit 15 as the MSB. Channel i occupies bits [16i+15:16i] of `dacCode`, and the full range 0 to 65535 is stored without change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| csN | input | 1 | Active-low chip select. Its rising edge completes a write |
| rdWrN | input | 1 | 1 = read, 0 = write |
| chAddr | input | 2 | Channel select |
| dataIn | input | 16 | Bus data from the host |
| dataOut | output | 16 | Readback data |
| dataOutEn | output | 1 | Bus drive enable for readback |
| loadIn | input | 1 | Load strobe, acts on its rising edge |
| clearIn | input | 1 | DAC clear strobe, acts on its rising edge |
| pwrDnN | input | 1 | Active-low power-down |
| dacCode | output | 64 | Four packed DAC register codes |
| chOutEn | output | 4 | Per-channel output enable. 0 means high impedance |

## Verification
Each channel is swept with all-zero, all-one, MSB-only, walking-one and channel-unique words. Reading back all four channels after each write separates a wrong address decode from a wrong data path. Loads and clears are interleaved with power-down toggles to show that clear and power-down act only on the DAC level, and that power-down hides the outputs without losing codes. Write and load are coincided, and so are load and clear, to pin down the ordering rules. A held load level is used to tell edge action from level action. A long pseudo-random run of mixed operations is then compared against a two-level model after every step.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;

  // Single-cycle strobes from control to datapath
  typedef struct packed {
    logic wrStb;     // store bus word into addressed staging register
    logic loadStb;   // copy all staging registers to DAC registers
    logic clearStb;  // zero all DAC registers
  } bankStrobes_t;

  localparam int unsigned NUM_STROBES = 3;

endpackage

// File: rtl/dacbank_sync.sv
module dacbank_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);

  generate
    if (STAGES <= 1) begin : g_single
      logic stage;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage <= RST_VAL;
        else       stage <= asyncIn;
      end
      assign syncOut = stage;
    end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= {STAGES{RST_VAL}};
        else       chain <= {chain[STAGES-2:0], asyncIn};
      end
      assign syncOut = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/dacbank_ctrl.sv
module dacbank_ctrl
  import dacbank_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         csN,
  input  logic         rdWrN,
  input  logic         loadIn,
  input  logic         clearIn,
  output bankStrobes_t stb
);

  // index 2: chip select, 1: load, 0: clear; all idle values listed here
  localparam logic [NUM_STROBES-1:0] IDLE_VAL = 3'b100;

  logic [NUM_STROBES-1:0] rawIn;
  logic [NUM_STROBES-1:0] syncIn;
  logic [NUM_STROBES-1:0] prevIn;
  logic [NUM_STROBES-1:0] riseDet;

  assign rawIn = {csN, loadIn, clearIn};

  generate
    for (genvar i = 0; i < NUM_STROBES; i++) begin : g_sync
      dacbank_sync #(
        .STAGES (SYNC_STAGES),
        .RST_VAL(IDLE_VAL[i])
      ) u_sync (
        .clk    (clk),
        .rstN   (rstN),
        .asyncIn(rawIn[i]),
        .syncOut(syncIn[i])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevIn <= IDLE_VAL;
    else       prevIn <= syncIn;
  end

  assign riseDet = syncIn & ~prevIn;

  // rdWrN is held by the host across the end of a write cycle
  always_comb begin
    stb.wrStb    = riseDet[2] & ~rdWrN;
    stb.loadStb  = riseDet[1];
    stb.clearStb = riseDet[0];
  end

  AST_WRITE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrStb |=> !stb.wrStb);                            // R2
  AST_LOAD_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadStb |=> !stb.loadStb);                        // R9

endmodule

// File: rtl/dacbank_dpath.sv
module dacbank_dpath
  import dacbank_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned ADDR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  bankStrobes_t                   stb,
  input  logic [ADDR_W-1:0]              wrAddr,
  input  logic [DATA_W-1:0]              wrData,
  input  logic [ADDR_W-1:0]              rdAddr,
  output logic [DATA_W-1:0]              rdData,
  output logic [NUM_CH-1:0][DATA_W-1:0]  dacRegs
);

  logic [NUM_CH-1:0][DATA_W-1:0] stageReg;
  logic [NUM_CH-1:0][DATA_W-1:0] dacReg;

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
      // staging level: written only by the host
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          stageReg[ch] <= '0;
        else if (stb.wrStb && (wrAddr == ADDR_W'(ch)))
          stageReg[ch] <= wrData;
      end

      // DAC level: clear has priority over load; load sees pre-write staging
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          dacReg[ch] <= '0;
        else if (stb.clearStb)
          dacReg[ch] <= '0;
        else if (stb.loadStb)
          dacReg[ch] <= stageReg[ch];
      end
    end
  endgenerate

  assign rdData  = stageReg[rdAddr];
  assign dacRegs = dacReg;

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrStb |=> stageReg[$past(wrAddr)] == $past(wrData));          // R2
  AST_LOAD_COPIES_OLD: assert property (@(posedge clk) disable iff (!rstN)
    (stb.loadStb && !stb.clearStb) |=> dacReg == $past(stageReg));    // R7
  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rstN)
    stb.clearStb |=> dacReg == '0);                                   // R8
  AST_CLEAR_KEEPS_STAGE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clearStb && !stb.wrStb) |=> $stable(stageReg));              // R5
  AST_DAC_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.clearStb && !stb.loadStb) |=> $stable(dacReg));             // R2

endmodule

// File: rtl/quad_dac_regbank.sv
module quad_dac_regbank
  import dacbank_pkg::*;
#(
  parameter int unsigned NUM_CH      = 4,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned ADDR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     csN,
  input  logic                     rdWrN,
  input  logic [ADDR_W-1:0]        chAddr,
  input  logic [DATA_W-1:0]        dataIn,
  output logic [DATA_W-1:0]        dataOut,
  output logic                     dataOutEn,
  input  logic                     loadIn,
  input  logic                     clearIn,
  input  logic                     pwrDnN,
  output logic [NUM_CH*DATA_W-1:0] dacCode,
  output logic [NUM_CH-1:0]        chOutEn
);

  bankStrobes_t                  stb;
  logic [NUM_CH-1:0][DATA_W-1:0] dacRegs;

  dacbank_ctrl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .csN    (csN),
    .rdWrN  (rdWrN),
    .loadIn (loadIn),
    .clearIn(clearIn),
    .stb    (stb)
  );

  dacbank_dpath #(
    .NUM_CH(NUM_CH),
    .DATA_W(DATA_W)
  ) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wrAddr (chAddr),
    .wrData (dataIn),
    .rdAddr (chAddr),
    .rdData (dataOut),
    .dacRegs(dacRegs)
  );

  assign dacCode   = dacRegs;
  assign dataOutEn = ~csN & rdWrN;
  assign chOutEn   = {NUM_CH{pwrDnN}};

  AST_PD_HOLDS_CODES: assert property (@(posedge clk) disable iff (!rstN)
    (!pwrDnN && !stb.clearStb && !stb.loadStb) |=> $stable(dacCode)); // R6
  AST_NO_DRIVE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !dataOutEn);                                              // R3

endmodule

// File: tb/sim_quad_dac_regbank.sv
module sim_quad_dac_regbank;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int DW  = 16;

  logic            clk = 1'b0;
  logic            rstN;
  logic            csN, rdWrN, loadIn, clearIn, pwrDnN;
  logic [1:0]      chAddr;
  logic [DW-1:0]   dataIn;
  logic [DW-1:0]   dataOut;
  logic            dataOutEn;
  logic [NCH*DW-1:0] dacCode;
  logic [NCH-1:0]  chOutEn;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] mStage [NCH];
  logic [DW-1:0] mDac   [NCH];

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_dac_regbank u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .rdWrN(rdWrN), .chAddr(chAddr),
    .dataIn(dataIn), .dataOut(dataOut), .dataOutEn(dataOutEn),
    .loadIn(loadIn), .clearIn(clearIn), .pwrDnN(pwrDnN),
    .dacCode(dacCode), .chOutEn(chOutEn)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doWrite(input int ch, input logic [DW-1:0] val);
    @(negedge clk);
    rdWrN = 1'b0; chAddr = 2'(ch); dataIn = val; csN = 1'b0;
    waitCyc(2);
    csN = 1'b1;
    waitCyc(5);
    mStage[ch] = val;
  endtask

  task automatic doLoad();
    @(negedge clk); loadIn = 1'b1;
    waitCyc(5); loadIn = 1'b0; waitCyc(2);
    for (int i = 0; i < NCH; i++) mDac[i] = mStage[i];
  endtask

  task automatic doClear();
    @(negedge clk); clearIn = 1'b1;
    waitCyc(5); clearIn = 1'b0; waitCyc(2);
    for (int i = 0; i < NCH; i++) mDac[i] = '0;
  endtask

  // compares DAC codes and every readback; ends with a cs rise in read mode
  task automatic checkAll(input string req);
    for (int i = 0; i < NCH; i++)
      chk({req, " dac"}, 32'(dacCode[i*DW +: DW]), 32'(mDac[i]));
    chk({req, " R6 oe"}, 32'(chOutEn), {28'd0, {NCH{pwrDnN}}});
    for (int i = 0; i < NCH; i++) begin
      @(negedge clk);
      rdWrN = 1'b1; chAddr = 2'(i); csN = 1'b0;
      #1;
      chk({req, " R3 rd"}, 32'(dataOut), 32'(mStage[i]));
      chk({req, " R3 en"}, 32'(dataOutEn), 32'd1);
      @(negedge clk); csN = 1'b1;
      #1;
      chk({req, " R3 idle"}, 32'(dataOutEn), 32'd0);
      waitCyc(5);
    end
    for (int i = 0; i < NCH; i++)
      chk({req, " R3 no write on read"}, 32'(dacCode[i*DW +: DW]), 32'(mDac[i]));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] pat;
    rstN = 1'b0; csN = 1'b1; rdWrN = 1'b0; chAddr = '0; dataIn = '0;
    loadIn = 1'b0; clearIn = 1'b0; pwrDnN = 1'b1;
    for (int i = 0; i < NCH; i++) begin mStage[i] = '0; mDac[i] = '0; end
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(2);
    checkAll("R1 reset");

    // R2/R10 sweep: patterns per channel, writes alone leave DAC codes alone
    for (int p = 0; p < 21; p++) begin
      for (int ch = 0; ch < NCH; ch++) begin
        case (p)
          0: pat = 16'h0000;
          1: pat = 16'hFFFF;
          2: pat = 16'h8000;
          3: pat = 16'h0001;
          4: pat = 16'(16'h1111 * (ch + 1));
          default: pat = 16'(1 << (p - 5)) ^ 16'(ch);
        endcase
        doWrite(ch, pat);
      end
      checkAll("R2 write sweep");
      doLoad();
      checkAll("R4 R10 load sweep");
    end

    // R5: clear touches only the DAC level
    doClear();
    checkAll("R5 clear");
    doLoad();
    checkAll("R5 stage kept after clear");

    // R6: power-down hides outputs, holds codes, clear still applies
    doWrite(2, 16'hA5A5); doLoad();
    @(negedge clk); pwrDnN = 1'b0;
    waitCyc(2);
    checkAll("R6 pd hold");
    @(negedge clk); pwrDnN = 1'b1; waitCyc(1);
    checkAll("R6 pd release");
    @(negedge clk); pwrDnN = 1'b0;
    doClear();
    checkAll("R6 clear in pd");
    @(negedge clk); pwrDnN = 1'b1; waitCyc(1);
    checkAll("R6 back at zero");

    // R7: write and load edges in the same cycle
    doLoad();
    @(negedge clk);
    rdWrN = 1'b0; chAddr = 2'd1; dataIn = 16'h3C3C; csN = 1'b0;
    waitCyc(2);
    csN = 1'b1; loadIn = 1'b1;
    waitCyc(5);
    loadIn = 1'b0; waitCyc(2);
    for (int i = 0; i < NCH; i++) mDac[i] = mStage[i];
    mStage[1] = 16'h3C3C;
    checkAll("R7 write with load");

    // R8: load and clear edges together
    @(negedge clk); loadIn = 1'b1; clearIn = 1'b1;
    waitCyc(5); loadIn = 1'b0; clearIn = 1'b0; waitCyc(2);
    for (int i = 0; i < NCH; i++) mDac[i] = '0;
    checkAll("R8 load with clear");

    // R9: a held load level does not follow later writes
    @(negedge clk); loadIn = 1'b1; waitCyc(5);
    for (int i = 0; i < NCH; i++) mDac[i] = mStage[i];
    doWrite(0, 16'h7E57);
    checkAll("R9 held load");
    @(negedge clk); loadIn = 1'b0; waitCyc(3);
    checkAll("R9 release");

    // mixed pseudo-random run against the model
    for (int n = 0; n < 150; n++) begin
      case ($urandom_range(0, 4))
        0, 1: doWrite(int'($urandom_range(0, 3)), 16'($urandom));
        2: doLoad();
        3: doClear();
        default: begin @(negedge clk); pwrDnN = ~pwrDnN; waitCyc(1); end
      endcase
      checkAll("R2 R4 R5 R6 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule